// File: doc/BRIEF.md
# Shared Request Queue with Distributed Address Decode

This block holds requests from a single master in an ordered queue and shows the oldest one to several slave ports at once. The master offers a request, made of an address and a payload, with a valid/ready handshake. An accepted request is stored behind the ones already waiting and is never overwritten. Every slave port sees the same head entry at the same time. Looking at the head does not consume it. There is no central router. Each slave port has its own address window, given as a base and a mask. The block raises a per-port match flag when the head address falls inside that window.

The slave that recognises the head removes it by raising its pop line. A pop delivers nothing to the slave: the head entry is discarded and the next request moves up. If several pops arrive in the same cycle, the lowest-numbered port wins and only one entry leaves. This event is recorded in a sticky multi-claim flag. A head that no window claims for four consecutive cycles is dropped and recorded in a sticky decode-error flag. Each sticky flag is cleared by a one-cycle write-one-to-clear pulse. The block also reports its current occupancy.

Top module: `reqq_peek_pop`

## Requirements
- R1: `put_ready` is high whenever the queue holds fewer than DEPTH entries. It is low when the queue is full and nothing leaves in that cycle. A put offered while `put_ready` is low is not stored. Accepted entries leave in the order they arrived.
- R2: `peek_valid` is high exactly when the queue is non-empty. While it is high, `peek_addr` and `peek_data` show the oldest entry and stay unchanged until that entry leaves.
- R3: `match[i]` is high exactly when `peek_valid` is high and `(peek_addr & mask_i) == base_i`. Here `base_i` and `mask_i` are bits `[i*AW +: AW]` of `win_base` and `win_mask`.
- R4: A cycle in which at least one `pop` bit is high and the queue is non-empty removes exactly the head entry. A `pop` while the queue is empty changes nothing: occupancy stays 0, no `taken` bit rises and no flag is set.
- R5: `taken` is one-hot or zero. It marks the lowest-index port whose pop removes the head in this cycle. When two or more `pop` bits are high on a non-empty queue, one entry leaves and `err_multi` is set.
- R6: If the head entry stays unmatched by every window and unpopped for 4 consecutive cycles, it is removed at the end of the fourth cycle and `err_decode` is set.
- R7: `err_decode` and `err_multi` are sticky. Bit 0 of `err_clr` clears `err_decode` and bit 1 clears `err_multi`, each on a one-cycle pulse. A clear has no effect on the other flag. A set in the same cycle as a clear leaves the flag set.
- R8: With the queue full, a put and a pop in the same cycle are both accepted: occupancy stays at DEPTH and the new entry is queued behind the others.
- R9: `occupancy` equals the number of stored entries after every clock edge.
- R10: While `rst_n` is low at a clock edge, the queue empties and both error flags clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| put_valid | input | 1 | Master offers a request |
| put_ready | output | 1 | Queue can take the offered request |
| put_addr | input | AW | Request address |
| put_data | input | DW | Request payload |
| win_base | input | NSLV*AW | Per-port window base, port i in bits [i*AW +: AW] |
| win_mask | input | NSLV*AW | Per-port window mask, port i in bits [i*AW +: AW] |
| peek_valid | output | 1 | A head entry is present |
| peek_addr | output | AW | Address of the head entry |
| peek_data | output | DW | Payload of the head entry |
| match | output | NSLV | Per-port window hit on the head entry |
| pop | input | NSLV | Per-port request to discard the head entry |
| taken | output | NSLV | Port whose pop removes the head this cycle |
| occupancy | output | $clog2(DEPTH+1) | Number of stored entries |
| err_decode | output | 1 | Sticky: an unclaimed head was dropped |
| err_multi | output | 1 | Sticky: more than one pop in one cycle |
| err_clr | input | 2 | Write-one-to-clear: bit 0 decode error, bit 1 multi-claim |

## Verification
The bench offers a fifth request to a full queue. A design that ignored `put_ready` would overwrite a waiting entry, and the pop order would then show a missing or foreign address. It also pushes and pops in the same cycle while the queue is full. Logic that gated ready on fullness alone would stall the master, and logic that counted wrongly would lose or duplicate an entry.

The bench raises every pop line against an empty queue. A design that did not qualify pops with occupancy would underflow the count or falsely raise `err_multi`. It raises two pops together and checks that exactly one entry leaves and that the lower port is reported. It holds an unclaimed head and checks that the head survives three cycles and vanishes on the fourth; an off-by-one timeout counter fails one side of that boundary. It then aligns a clear pulse with a drop to confirm that the set wins. It also checks that each clear bit touches only its own flag.

// File: rtl/reqq_pkg.sv
package reqq_pkg;
    // Bit positions inside the write-one-to-clear vector.
    localparam int CLR_DECODE = 0;
    localparam int CLR_MULTI  = 1;
    localparam int CLR_W      = 2;
endpackage

// File: rtl/reqq_store.sv
module reqq_store #(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    input  logic          deq,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t st_q, st_d;
    logic [AW-1:0] addr_mem [DEPTH];
    logic [DW-1:0] data_mem [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        if (p == PW'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) st_d.wr = bump(st_q.wr);
        if (deq)  st_d.rd = bump(st_q.rd);
        case ({push, deq})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) begin
            addr_mem[st_q.wr] <= in_addr;
            data_mem[st_q.wr] <= in_data;
        end
    end

    assign head_addr = addr_mem[st_q.rd];
    assign head_data = data_mem[st_q.rd];
    assign count     = st_q.cnt;
    assign full      = (st_q.cnt == CW'(DEPTH));
    assign empty     = (st_q.cnt == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH)); // R9
    AST_FULL_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !deq) |-> !push); // R1
    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !deq) |=> (st_q.cnt == CW'($past(st_q.cnt) + 1'b1))); // R9
    AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push) |=> empty); // R4
endmodule

// File: rtl/reqq_window.sv
module reqq_window #(
    parameter int AW = 16
) (
    input  logic          head_valid,
    input  logic [AW-1:0] head_addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] mask,
    output logic          hit
);
    always_comb begin
        hit = head_valid && ((head_addr & mask) == base);
    end
endmodule

// File: rtl/reqq_guard.sv
module reqq_guard
    import reqq_pkg::*;
#(
    parameter int NSLV    = 3,
    parameter int TIMEOUT = 4,
    localparam int TW     = $clog2(TIMEOUT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              head_valid,
    input  logic              any_match,
    input  logic [NSLV-1:0]   pop,
    input  logic [CLR_W-1:0]  err_clr,
    output logic [NSLV-1:0]   taken,
    output logic              deq,
    output logic              err_decode,
    output logic              err_multi
);
    typedef struct packed {
        logic [TW-1:0] wait_cnt;
        logic          dec_err;
        logic          multi_err;
    } guard_t;

    guard_t g_q, g_d;
    logic [NSLV-1:0] pop_live;
    logic            found;
    logic            multi;
    logic            drop;

    always_comb begin
        pop_live = pop & {NSLV{head_valid}};
        taken    = '0;
        found    = 1'b0;
        for (int i = 0; i < NSLV; i++) begin
            if (pop_live[i] && !found) begin
                taken[i] = 1'b1;
                found    = 1'b1;
            end
        end
        multi = ($countones(pop_live) > 1);
        drop  = head_valid && !any_match && !found &&
                (g_q.wait_cnt == TW'(TIMEOUT - 1));
        deq   = found || drop;

        g_d = g_q;
        if (!head_valid || any_match || deq) g_d.wait_cnt = '0;
        else                                 g_d.wait_cnt = g_q.wait_cnt + 1'b1;

        if (drop)                     g_d.dec_err = 1'b1;
        else if (err_clr[CLR_DECODE]) g_d.dec_err = 1'b0;

        if (multi)                    g_d.multi_err = 1'b1;
        else if (err_clr[CLR_MULTI])  g_d.multi_err = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign err_decode = g_q.dec_err;
    assign err_multi  = g_q.multi_err;

    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> err_decode); // R6
    AST_MULTI_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        multi |=> err_multi); // R5
    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        g_q.wait_cnt < TW'(TIMEOUT)); // R6
    AST_DEQ_NEEDS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        deq |-> head_valid); // R4
endmodule

// File: rtl/reqq_peek_pop.sv
module reqq_peek_pop
    import reqq_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 16,
    parameter int DEPTH   = 4,
    parameter int NSLV    = 3,
    parameter int TIMEOUT = 4,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                put_valid,
    output logic                put_ready,
    input  logic [AW-1:0]       put_addr,
    input  logic [DW-1:0]       put_data,
    input  logic [NSLV*AW-1:0]  win_base,
    input  logic [NSLV*AW-1:0]  win_mask,
    output logic                peek_valid,
    output logic [AW-1:0]       peek_addr,
    output logic [DW-1:0]       peek_data,
    output logic [NSLV-1:0]     match,
    input  logic [NSLV-1:0]     pop,
    output logic [NSLV-1:0]     taken,
    output logic [CW-1:0]       occupancy,
    output logic                err_decode,
    output logic                err_multi,
    input  logic [CLR_W-1:0]    err_clr
);
    logic full, empty, deq, push;

    reqq_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) store_i (
        .clk(clk), .rst_n(rst_n), .push(push), .in_addr(put_addr),
        .in_data(put_data), .deq(deq), .head_addr(peek_addr),
        .head_data(peek_data), .count(occupancy), .full(full), .empty(empty)
    );

    assign peek_valid = !empty;

    for (genvar i = 0; i < NSLV; i++) begin : g_win
        reqq_window #(.AW(AW)) win_i (
            .head_valid(peek_valid), .head_addr(peek_addr),
            .base(win_base[i*AW +: AW]), .mask(win_mask[i*AW +: AW]),
            .hit(match[i])
        );
    end

    reqq_guard #(.NSLV(NSLV), .TIMEOUT(TIMEOUT)) guard_i (
        .clk(clk), .rst_n(rst_n), .head_valid(peek_valid),
        .any_match(|match), .pop(pop), .err_clr(err_clr), .taken(taken),
        .deq(deq), .err_decode(err_decode), .err_multi(err_multi)
    );

    assign put_ready = !full || deq;
    assign push      = put_valid && put_ready;

    AST_MATCH_NEEDS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (|match) |-> peek_valid); // R3
    AST_ONE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(taken)); // R5
    AST_TAKEN_FROM_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (taken & ~pop) == '0); // R5
    AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (peek_valid && !deq) |=> ($stable(peek_addr) && $stable(peek_data))); // R2
endmodule

// File: tb/reqq_peek_pop_tb.sv
module reqq_peek_pop_tb_top;
    localparam int AW = 16, DW = 16, DEPTH = 4, NSLV = 3, TIMEOUT = 4;
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic put_valid = 1'b0;
    logic put_ready;
    logic [AW-1:0] put_addr = '0;
    logic [DW-1:0] put_data = '0;
    logic [NSLV*AW-1:0] win_base, win_mask;
    logic peek_valid;
    logic [AW-1:0] peek_addr;
    logic [DW-1:0] peek_data;
    logic [NSLV-1:0] match, taken;
    logic [NSLV-1:0] pop = '0;
    logic [CW-1:0] occupancy;
    logic err_decode, err_multi;
    logic [1:0] err_clr = '0;

    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    assign win_base = {16'h3000, 16'h2000, 16'h1000};
    assign win_mask = {16'hF000, 16'hF000, 16'hF000};

    reqq_peek_pop #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .NSLV(NSLV), .TIMEOUT(TIMEOUT)) dut_i (
        .clk(clk), .rst_n(rst_n), .put_valid(put_valid), .put_ready(put_ready),
        .put_addr(put_addr), .put_data(put_data), .win_base(win_base),
        .win_mask(win_mask), .peek_valid(peek_valid), .peek_addr(peek_addr),
        .peek_data(peek_data), .match(match), .pop(pop), .taken(taken),
        .occupancy(occupancy), .err_decode(err_decode), .err_multi(err_multi),
        .err_clr(err_clr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push1(input logic [15:0] a, input logic [15:0] d);
        put_valid = 1'b1; put_addr = a; put_data = d;
        @(negedge clk);
        put_valid = 1'b0;
    endtask

    task automatic pop1(input logic [NSLV-1:0] who);
        pop = who;
        @(negedge clk);
        pop = '0;
    endtask

    task automatic t_reset();
        chk(peek_valid == 1'b0, "R10 peek_valid", int'(peek_valid), 0);
        chk(occupancy == 0, "R10 occupancy", int'(occupancy), 0);
        chk(put_ready == 1'b1, "R10 put_ready", int'(put_ready), 1);
        chk(!err_decode && !err_multi, "R10 flags", int'({err_decode, err_multi}), 0);
        chk(match == 0, "R10 match", int'(match), 0);
    endtask

    task automatic t_fill_order();
        for (int k = 0; k < DEPTH; k++) begin
            push1(16'h1000 + 16'(k), 16'h00A0 + 16'(k));
            chk(int'(occupancy) == k + 1, "R9 count while filling", int'(occupancy), k + 1);
        end
        chk(put_ready == 1'b0, "R1 ready low when full", int'(put_ready), 0);
        push1(16'h1FFF, 16'hDEAD);
        chk(int'(occupancy) == DEPTH, "R1 put refused when full", int'(occupancy), DEPTH);
        for (int k = 0; k < DEPTH; k++) begin
            chk(peek_addr == 16'h1000 + 16'(k), "R1 order addr", int'(peek_addr), 'h1000 + k);
            chk(peek_data == 16'h00A0 + 16'(k), "R2 head data", int'(peek_data), 'hA0 + k);
            pop1(3'b001);
        end
        chk(peek_valid == 1'b0, "R2 empty after drain", int'(peek_valid), 0);
        chk(occupancy == 0, "R4 drained count", int'(occupancy), 0);
    endtask

    task automatic t_peek_hold();
        push1(16'h2010, 16'h0011);
        for (int k = 0; k < 6; k++) begin
            chk(match == 3'b010, "R3 match slave1", int'(match), 2);
            chk(peek_addr == 16'h2010, "R2 peek not consuming", int'(peek_addr), 'h2010);
            @(negedge clk);
        end
        chk(occupancy == 1 && !err_decode, "R6 matched head kept", int'(occupancy), 1);
        push1(16'h3020, 16'h0022);
        chk(peek_addr == 16'h2010, "R2 head after second put", int'(peek_addr), 'h2010);
        pop1(3'b010);
        chk(peek_addr == 16'h3020 && match == 3'b100, "R3 match slave2", int'(match), 4);
        pop1(3'b100);
        chk(match == 0 && !peek_valid, "R3 no match when empty", int'(match), 0);
    endtask

    task automatic t_full_swap();
        for (int k = 0; k < DEPTH; k++) push1(16'h1000 + 16'(k), 16'(k));
        put_valid = 1'b1; put_addr = 16'h1100; put_data = 16'h0077; pop = 3'b001;
        #1;
        chk(put_ready == 1'b1, "R8 ready with pop when full", int'(put_ready), 1);
        @(negedge clk);
        put_valid = 1'b0; pop = '0;
        chk(int'(occupancy) == DEPTH, "R8 count kept", int'(occupancy), DEPTH);
        chk(peek_addr == 16'h1001, "R8 head advanced", int'(peek_addr), 'h1001);
        for (int k = 0; k < DEPTH - 1; k++) pop1(3'b001);
        chk(peek_addr == 16'h1100 && peek_data == 16'h0077, "R8 new entry queued",
            int'(peek_addr), 'h1100);
        pop1(3'b001);
        chk(occupancy == 0, "R8 drained", int'(occupancy), 0);
    endtask

    task automatic t_empty_pop();
        pop = 3'b111;
        #1;
        chk(taken == 0, "R4 no taken on empty", int'(taken), 0);
        @(negedge clk);
        pop = '0;
        chk(occupancy == 0, "R4 empty pop ignored", int'(occupancy), 0);
        chk(err_multi == 1'b0, "R4 no multi flag on empty", int'(err_multi), 0);
        push1(16'h2000, 16'h0055);
        chk(occupancy == 1 && peek_addr == 16'h2000, "R4 queue usable", int'(peek_addr), 'h2000);
        pop1(3'b010);
    endtask

    task automatic t_multi();
        push1(16'h1000, 16'h0001);
        push1(16'h1001, 16'h0002);
        pop = 3'b110;
        #1;
        chk(taken == 3'b010, "R5 lowest wins", int'(taken), 2);
        @(negedge clk);
        pop = '0;
        chk(occupancy == 1, "R5 one entry removed", int'(occupancy), 1);
        chk(peek_addr == 16'h1001, "R5 next head", int'(peek_addr), 'h1001);
        chk(err_multi == 1'b1, "R5 multi flag set", int'(err_multi), 1);
        @(negedge clk);
        chk(err_multi == 1'b1, "R7 multi sticky", int'(err_multi), 1);
        err_clr = 2'b01;
        @(negedge clk);
        err_clr = 2'b00;
        chk(err_multi == 1'b1, "R7 decode clear leaves multi", int'(err_multi), 1);
        err_clr = 2'b10;
        @(negedge clk);
        err_clr = 2'b00;
        chk(err_multi == 1'b0, "R7 multi cleared", int'(err_multi), 0);
        pop1(3'b001);
    endtask

    task automatic t_timeout();
        push1(16'h5000, 16'h0099);
        for (int k = 0; k < TIMEOUT - 1; k++) begin
            @(negedge clk);
            chk(occupancy == 1, "R6 head held before limit", int'(occupancy), 1);
        end
        chk(err_decode == 1'b0, "R6 no flag before limit", int'(err_decode), 0);
        @(negedge clk);
        chk(occupancy == 0, "R6 head dropped", int'(occupancy), 0);
        chk(err_decode == 1'b1, "R6 decode flag", int'(err_decode), 1);
        @(negedge clk);
        chk(err_decode == 1'b1, "R7 decode sticky", int'(err_decode), 1);
        err_clr = 2'b10;
        @(negedge clk);
        err_clr = 2'b00;
        chk(err_decode == 1'b1, "R7 multi clear leaves decode", int'(err_decode), 1);
        err_clr = 2'b01;
        @(negedge clk);
        err_clr = 2'b00;
        chk(err_decode == 1'b0, "R7 decode cleared", int'(err_decode), 0);
        push1(16'h5001, 16'h0098);
        for (int k = 0; k < TIMEOUT - 1; k++) @(negedge clk);
        err_clr = 2'b01;
        @(negedge clk);
        err_clr = 2'b00;
        chk(err_decode == 1'b1 && occupancy == 0, "R7 set wins over clear",
            int'(err_decode), 1);
        err_clr = 2'b01;
        @(negedge clk);
        err_clr = 2'b00;
    endtask

    task automatic t_reset_mid();
        push1(16'h1000, 16'h0001);
        push1(16'h5000, 16'h0002);
        pop1(3'b011);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(occupancy == 0 && !peek_valid, "R10 reset empties", int'(occupancy), 0);
        chk(!err_multi && !err_decode, "R10 reset clears flags", int'({err_decode, err_multi}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill_order();
        t_peek_hold();
        t_full_swap();
        t_empty_pop();
        t_multi();
        t_timeout();
        t_reset_mid();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule